// File: doc/BRIEF.md
# Configuration Error and Startup Sequencer

This block is the control state machine that carries a programmable device from an idle state through loading, error recovery and initialization into user mode. An active-low configuration request input holds the device in idle while it is low, and starts a load when it returns high. The data loader, which is outside this block, reports either a finished load or an error. On an error the block pulls an open-drain active-low status line low for a fixed time-out. It then releases the line and waits, through a two-flop synchronizer, until the line actually reads high. An external agent may hold the line low for longer.

After recovery the block either reloads on its own or stops until the request input is toggled, depending on a static option. After a good load it counts a fixed number of initialization clock ticks. The tick source is either an internal oscillator or a user clock, chosen by an option input. It then releases the global register clear and the global output tri-state in a selectable order, one tick apart, and raises done together with the second release. In user mode, two optional global pins may force the register clear or the output tri-state again. Static options enable or disable each pin.

Top module: `cfgSeq`

## Requirements
- R1: While `rstN` is low and, after reset, while `cfgReqN` is low, the block holds `outHiZ`=1, `regClear`=1, `cfgDone`=0 and `statusLowOut`=0.
- R2: When `loadErr` is sampled high during loading, `statusLowOut` is high from the next cycle for exactly RESET_CYCLES cycles, then goes low.
- R3: After the status line is released, the block waits while `statusPadIn` reads 0. Once the pad reads 1, the next state is taken on the third clock edge (two synchronizer flops plus the state register).
- R4: With `optAutoRestart`=1, the block returns to loading after the status line reads high, with no toggle of `cfgReqN`. A `loadDone` held from the release then produces the first release step after INIT_CYCLES+4 cycles, given a tick in every cycle.
- R5: With `optAutoRestart`=0, the block stops after the error, and `loadDone` has no effect until `cfgReqN` goes low and then high again.
- R6: `outHiZ` and `regClear` stay 1 during idle, loading, error, recovery and initialization.
- R7: Initialization advances only on ticks of the selected source: `userTick` when `optUserClk`=1, `oscTick` when it is 0. The first release step comes on the INIT_CYCLES-th selected tick after `loadDone`.
- R8: With `optClearFirst`=0, `outHiZ` falls first and `regClear` falls one selected tick later. With `optClearFirst`=1 the order is reversed. `cfgDone` rises in the same cycle as the second release.
- R9: In user mode, `regClear` equals `optGlobalClr & ~gClrPinN`. With the option at 0, the pin has no effect.
- R10: In user mode, `outHiZ` equals `optGlobalOe & ~gOePinN`. With the option at 0, the pin has no effect.
- R11: `cfgReqN` sampled low at any edge returns the block to idle at that edge. This clears `cfgDone` and asserts `outHiZ` and `regClear`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgReqN | input | 1 | Active-low configuration request |
| loadErr | input | 1 | Error strobe from the data loader |
| loadDone | input | 1 | Load complete strobe from the data loader |
| statusPadIn | input | 1 | Level read back from the status line, pull-up included |
| statusLowOut | output | 1 | 1 pulls the open-drain status line low |
| oscTick | input | 1 | Tick enable from the internal oscillator |
| userTick | input | 1 | Tick enable from the user clock pin |
| optAutoRestart | input | 1 | 1 reloads on its own after an error |
| optClearFirst | input | 1 | 1 releases the register clear before the tri-state |
| optUserClk | input | 1 | 1 selects userTick as the initialization clock |
| optGlobalClr | input | 1 | Enables the global clear pin |
| optGlobalOe | input | 1 | Enables the global output-enable pin |
| gClrPinN | input | 1 | Active-low global register clear pin |
| gOePinN | input | 1 | Active-low global output-enable pin |
| regClear | output | 1 | Global clear applied to all user registers |
| outHiZ | output | 1 | Global tri-state applied to all user outputs |
| cfgDone | output | 1 | Configuration complete, user mode |

## Verification
A counter stuck or off by one shows up directly in the width of the `statusLowOut` pulse, or in how many ticks pass before the first release. Both are measured to the exact cycle. A wrong recovery state shows within a few cycles of the pad going high. The block either reloads when it should stop, or ignores `loadDone` when it should accept it. A swapped release order or a wrong tick source changes which of `outHiZ` and `regClear` falls first, and whether anything falls at all while only the unselected source ticks.

// File: rtl/cfgSeqPkg.sv
`timescale 1ns/1ps
package cfgSeqPkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_ERR, ST_RELW, ST_HALT, ST_INIT, ST_STEP, ST_USER
  } seqState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic driveStatus;
    logic relFirst;
    logic relSecond;
  } ctlStrobes_t;
endpackage

// File: rtl/cfgSeqDatapath.sv
`timescale 1ns/1ps
module cfgSeqDatapath
  import cfgSeqPkg::*;
#(
  parameter int RESET_CYCLES = 64,
  parameter int INIT_CYCLES  = 32,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t stb,
  input  logic        statusPadIn,
  input  logic        oscTick,
  input  logic        userTick,
  input  logic        optUserClk,
  input  logic        optClearFirst,
  input  logic        optGlobalClr,
  input  logic        optGlobalOe,
  input  logic        gClrPinN,
  input  logic        gOePinN,
  output logic        toHit,
  output logic        initHit,
  output logic        initTick,
  output logic        statusHigh,
  output logic        statusLowOut,
  output logic        regClear,
  output logic        outHiZ,
  output logic        cfgDone
);
  localparam int CNT_MAX = (RESET_CYCLES > INIT_CYCLES) ? RESET_CYCLES : INIT_CYCLES;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic [CW-1:0] cnt;
  logic [SYNC_STAGES-1:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (stb.cntClr) cnt <= '0;
    else if (stb.cntInc) cnt <= cnt + 1'b1;
  end

  assign toHit    = (cnt == CW'(RESET_CYCLES - 1));
  assign initHit  = (cnt == CW'(INIT_CYCLES - 1));
  assign initTick = optUserClk ? userTick : oscTick;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= statusPadIn;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= syncQ[g-1];
      end
    end
  endgenerate

  assign statusHigh = syncQ[SYNC_STAGES-1];

  logic hiZReleased, clrReleased;
  assign hiZReleased  = optClearFirst ? stb.relSecond : stb.relFirst;
  assign clrReleased  = optClearFirst ? stb.relFirst  : stb.relSecond;
  assign outHiZ       = !hiZReleased || (optGlobalOe  && !gOePinN);
  assign regClear     = !clrReleased || (optGlobalClr && !gClrPinN);
  assign statusLowOut = stb.driveStatus;
  assign cfgDone      = stb.relSecond;
endmodule

// File: rtl/cfgSeqCtrl.sv
`timescale 1ns/1ps
module cfgSeqCtrl
  import cfgSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgReqN,
  input  logic        loadErr,
  input  logic        loadDone,
  input  logic        optAutoRestart,
  input  logic        toHit,
  input  logic        initHit,
  input  logic        initTick,
  input  logic        statusHigh,
  output ctlStrobes_t stb
);
  seqState_t cur, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cur <= ST_IDLE;
    else       cur <= nxt;
  end

  always_comb begin
    nxt             = cur;
    stb             = '0;
    stb.driveStatus = (cur == ST_ERR);
    stb.relFirst    = (cur == ST_STEP) || (cur == ST_USER);
    stb.relSecond   = (cur == ST_USER);
    case (cur)
      ST_IDLE: begin
        stb.cntClr = 1'b1;
        nxt        = ST_LOAD;
      end
      ST_LOAD: begin
        stb.cntClr = 1'b1;
        if (loadErr)       nxt = ST_ERR;
        else if (loadDone) nxt = ST_INIT;
      end
      ST_ERR: begin
        if (toHit) begin
          stb.cntClr = 1'b1;
          nxt        = ST_RELW;
        end else begin
          stb.cntInc = 1'b1;
        end
      end
      ST_RELW: if (statusHigh) nxt = optAutoRestart ? ST_LOAD : ST_HALT;
      ST_HALT: nxt = ST_HALT;
      ST_INIT: begin
        if (initTick) begin
          if (initHit) begin
            stb.cntClr = 1'b1;
            nxt        = ST_STEP;
          end else begin
            stb.cntInc = 1'b1;
          end
        end
      end
      ST_STEP: if (initTick) nxt = ST_USER;
      ST_USER: nxt = ST_USER;
      default: nxt = ST_IDLE;
    endcase
    if (!cfgReqN) nxt = ST_IDLE;
  end
endmodule

// File: rtl/cfgSeq.sv
`timescale 1ns/1ps
module cfgSeq
  import cfgSeqPkg::*;
#(
  parameter int RESET_CYCLES = 64,
  parameter int INIT_CYCLES  = 32,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgReqN,
  input  logic loadErr,
  input  logic loadDone,
  input  logic statusPadIn,
  output logic statusLowOut,
  input  logic oscTick,
  input  logic userTick,
  input  logic optAutoRestart,
  input  logic optClearFirst,
  input  logic optUserClk,
  input  logic optGlobalClr,
  input  logic optGlobalOe,
  input  logic gClrPinN,
  input  logic gOePinN,
  output logic regClear,
  output logic outHiZ,
  output logic cfgDone
);
  ctlStrobes_t stb;
  logic toHit, initHit, initTick, statusHigh;

  cfgSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cfgReqN(cfgReqN), .loadErr(loadErr),
    .loadDone(loadDone), .optAutoRestart(optAutoRestart), .toHit(toHit),
    .initHit(initHit), .initTick(initTick), .statusHigh(statusHigh), .stb(stb)
  );

  cfgSeqDatapath #(
    .RESET_CYCLES(RESET_CYCLES), .INIT_CYCLES(INIT_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .statusPadIn(statusPadIn),
    .oscTick(oscTick), .userTick(userTick), .optUserClk(optUserClk),
    .optClearFirst(optClearFirst), .optGlobalClr(optGlobalClr),
    .optGlobalOe(optGlobalOe), .gClrPinN(gClrPinN), .gOePinN(gOePinN),
    .toHit(toHit), .initHit(initHit), .initTick(initTick),
    .statusHigh(statusHigh), .statusLowOut(statusLowOut),
    .regClear(regClear), .outHiZ(outHiZ), .cfgDone(cfgDone)
  );
endmodule

// File: rtl/cfgSeqChecker.sv
`timescale 1ns/1ps
module cfgSeqChecker (
  input logic clk,
  input logic rstN,
  input logic cfgReqN,
  input logic loadErr,
  input logic statusLowOut,
  input logic oscTick,
  input logic userTick,
  input logic optUserClk,
  input logic regClear,
  input logic outHiZ,
  input logic cfgDone
);
  AST_ERR_NEEDS_LOADERR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusLowOut) |-> $past(loadErr)); // R2

  AST_ERR_HOLDS_OUTPUTS: assert property (@(posedge clk) disable iff (!rstN)
    statusLowOut |-> (outHiZ && regClear && !cfgDone)); // R6

  AST_REQ_LOW_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cfgReqN |=> (!cfgDone && !statusLowOut && outHiZ && regClear)); // R11

  AST_DONE_AFTER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgDone) |-> $past(outHiZ || regClear)); // R8

  AST_DONE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgDone) |-> $past(optUserClk ? userTick : oscTick)); // R7

  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |-> (outHiZ && regClear && !cfgDone && !statusLowOut)); // R1
endmodule

bind cfgSeq cfgSeqChecker uChk (
  .clk(clk), .rstN(rstN), .cfgReqN(cfgReqN), .loadErr(loadErr),
  .statusLowOut(statusLowOut), .oscTick(oscTick), .userTick(userTick),
  .optUserClk(optUserClk), .regClear(regClear), .outHiZ(outHiZ), .cfgDone(cfgDone)
);

// File: tb/tb_cfgSeq.sv
`timescale 1ns/1ps
module tb_cfgSeq;
  localparam int TO   = 6;
  localparam int INIT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgReqN = 1'b0, loadErr = 1'b0, loadDone = 1'b0, extHold = 1'b0;
  logic oscTick = 1'b0, userTick = 1'b0;
  logic optAutoRestart = 1'b0, optClearFirst = 1'b0, optUserClk = 1'b0;
  logic optGlobalClr = 1'b0, optGlobalOe = 1'b0, gClrPinN = 1'b1, gOePinN = 1'b1;
  logic statusPadIn, statusLowOut, regClear, outHiZ, cfgDone;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  assign statusPadIn = !(statusLowOut || extHold);

  cfgSeq #(.RESET_CYCLES(TO), .INIT_CYCLES(INIT), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .cfgReqN(cfgReqN), .loadErr(loadErr), .loadDone(loadDone),
    .statusPadIn(statusPadIn), .statusLowOut(statusLowOut), .oscTick(oscTick),
    .userTick(userTick), .optAutoRestart(optAutoRestart), .optClearFirst(optClearFirst),
    .optUserClk(optUserClk), .optGlobalClr(optGlobalClr), .optGlobalOe(optGlobalOe),
    .gClrPinN(gClrPinN), .gOePinN(gOePinN), .regClear(regClear), .outHiZ(outHiZ),
    .cfgDone(cfgDone)
  );

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setTicks(input logic sel, input logic other);
    if (optUserClk) begin userTick = sel; oscTick = other; end
    else begin oscTick = sel; userTick = other; end
  endtask

  function automatic int pack4();
    return {28'd0, outHiZ, regClear, cfgDone, statusLowOut};
  endfunction

  task automatic checkHeld(input string req);
    check(outHiZ && regClear && !cfgDone && !statusLowOut, req, pack4(), 4'b1100);
  endtask

  // from LOAD state: init, release order, global pins, request drop
  task automatic initPath();
    int n;
    setTicks(1'b0, 1'b1);
    loadDone = 1'b1; step(); loadDone = 1'b0;
    for (int i = 0; i < 8; i++) step();
    checkHeld("R7 unselected source must not advance");
    setTicks(1'b1, 1'b0);
    n = 0;
    while (outHiZ && regClear && n < 100) begin step(); n++; end
    check(n == INIT, "R7 ticks to first release", n, INIT);
    if (optClearFirst)
      check(!regClear && outHiZ && !cfgDone, "R8 clear released first", pack4(), 4'b1000);
    else
      check(!outHiZ && regClear && !cfgDone, "R8 tri-state released first", pack4(), 4'b0100);
    step();
    check(!outHiZ && !regClear && cfgDone, "R8 second release with done", pack4(), 4'b0010);
    for (int k = 0; k < 16; k++) begin
      optGlobalClr = k[0]; optGlobalOe = k[1]; gClrPinN = k[2]; gOePinN = k[3];
      #1;
      check(regClear == (optGlobalClr && !gClrPinN), "R9 global clear pin", regClear,
            int'(optGlobalClr && !gClrPinN));
      check(outHiZ == (optGlobalOe && !gOePinN), "R10 global output-enable pin", outHiZ,
            int'(optGlobalOe && !gOePinN));
    end
    optGlobalClr = 0; optGlobalOe = 0; gClrPinN = 1; gOePinN = 1;
    cfgReqN = 1'b0; step();
    checkHeld("R11 request low returns to idle");
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    @(negedge clk); @(negedge clk);
    checkHeld("R1 during reset");
    rstN = 1'b1;
    step(); step();
    checkHeld("R1 request low after reset");
    for (int c = 0; c < 8; c++) begin
      optClearFirst = c[0]; optAutoRestart = c[1]; optUserClk = c[2];
      setTicks(1'b1, 1'b0);
      cfgReqN = 1'b0; step(); step();
      checkHeld("R1 idle");
      cfgReqN = 1'b1; step();           // now loading
      checkHeld("R6 loading");
      loadErr = 1'b1; extHold = 1'b1; step(); loadErr = 1'b0;
      n = 0;
      while (statusLowOut && n < 100) begin
        n++;
        if (!(outHiZ && regClear)) check(0, "R6 error state", pack4(), 4'b1101);
        step();
      end
      check(n == TO, "R2 status low duration", n, TO);
      for (int i = 0; i < 5; i++) step();
      checkHeld("R3 waiting while line held low");
      extHold = 1'b0; loadDone = 1'b1;
      if (optAutoRestart) begin
        n = 0;
        while (outHiZ && regClear && n < 100) begin step(); n++; end
        check(n == INIT + 4, "R3 R4 auto restart latency", n, INIT + 4);
        loadDone = 1'b0;
        step();
        check(cfgDone == 1'b1, "R4 auto restart reaches user mode", cfgDone, 1);
      end else begin
        for (int i = 0; i < INIT + 10; i++) step();
        checkHeld("R5 halted ignores loadDone");
        loadDone = 1'b0;
      end
      cfgReqN = 1'b0; step(); cfgReqN = 1'b1; step();   // loading again
      initPath();
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule